// File: doc/BRIEF.md
# Coarse and Fine Event Timestamp Unit

This block records when each trigger arrives. A coarse counter advances once per master-clock period, and a fine counter advances on every edge of a faster sampling clock that is ten times the master rate. Both clocks are represented by a single fast clock `clk` together with a master-period enable `tick_en`, which is high for one fast cycle in every ten.

When the trigger input rises, the block takes the coarse and fine values on the next fast edge and stores them as one word in a small first-in first-out buffer. A downstream packing unit reads the words out with a read strobe. Flags show when the buffer is empty or full. A sticky flag records any trigger that was lost because the buffer was full.

Top module: `event_timestamp_unit`

## Requirements
- R1: The coarse counter is 16 bits wide. It increments on every fast edge where `tick_en` is high, and it wraps from 0xFFFF to 0x0000 without stalling.
- R2: The fine counter is 4 bits wide. It is cleared to 0 on a fast edge where `tick_en` is high. On every other edge it increments, and it holds once it reaches 9, so its values run 0 to 9.
- R3: A stored word places the coarse count in bits 19:4 and the fine count in bits 3:0. Both are the values the counters hold during the cycle that ends at the capture edge, before that edge updates them.
- R4: A capture occurs on a fast edge where `trig_in` is high and `trig_in` was low at the previous edge. A trigger that stays high is captured only once.
- R5: The buffer holds 8 words and returns them in arrival order. A `rd_en` on an edge where the buffer is non-empty places the oldest word on `rd_data` at that edge. A `rd_en` while the buffer is empty is ignored, and `rd_data` keeps its value.
- R6: After each edge, `empty` is high exactly when no words are held, and `full` is high exactly when 8 words are held.
- R7: A capture on an edge where `full` is high is dropped and leaves the stored words unchanged, even if a read happens on the same edge. It sets `overflow`, which then stays high until reset.
- R8: While `rst` is high at an edge, both counters clear to 0, the buffer empties, and `overflow` and `rd_data` clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Master-period enable, one fast cycle per master period |
| trig_in | input | 1 | Trigger start level |
| rd_en | input | 1 | Read strobe from the packing unit |
| rd_data | output | 20 | Oldest word read out, registered |
| empty | output | 1 | Buffer holds no words |
| full | output | 1 | Buffer holds 8 words |
| overflow | output | 1 | Sticky flag: a trigger was dropped |

## Verification
A capture is written on the first edge at which the trigger is seen high, and it can be read at the edge that follows. The word appears on `rd_data` on the same edge that accepts `rd_en`. The flags and `overflow` reflect the result of each edge as soon as that edge has passed. The bench drives inputs on the falling edge and updates its reference model for the rising edge it has just stepped over. It then compares every output one time unit after that edge, so each result is checked in exactly the cycle in which it is due.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_COARSE_W = 16;
  localparam int unsigned TS_FINE_W   = 4;
  localparam int unsigned TS_DIV      = 10;
  localparam int unsigned TS_DEPTH    = 8;
endpackage

// File: rtl/ts_time_counter.sv
module ts_time_counter #(
  parameter int unsigned COARSE_W = 16,
  parameter int unsigned FINE_W   = 4,
  parameter int unsigned DIV      = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  output logic [COARSE_W-1:0] coarse,
  output logic [FINE_W-1:0]   fine
);
  localparam logic [FINE_W-1:0] FINE_LAST = FINE_W'(DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse <= '0;
      fine   <= '0;
    end else if (tick_en) begin
      coarse <= coarse + 1'b1;
      fine   <= '0;
    end else if (fine != FINE_LAST) begin
      fine <= fine + 1'b1;
    end
  end

  // R2: fine value never leaves 0..DIV-1
  p_fine_range_r2: assert property (@(posedge clk) disable iff (rst)
    fine <= FINE_LAST);
  // R1: coarse steps by one on every master tick, wrapping naturally
  p_coarse_step_r1: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> coarse == $past(coarse) + 1'b1);
  // R1: coarse holds without a tick
  p_coarse_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(coarse));
endmodule

// File: rtl/ts_trig_edge.sv
module ts_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic capture
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_in;
  end

  assign capture = trig_in & ~trig_q;

  // R4: a held trigger yields one capture only
  p_single_capture_r4: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);
endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo #(
  parameter int unsigned W     = 20,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nx;
  logic          wr_ok, rd_ok;

  assign wr_ok    = wr_req && !full;
  assign rd_ok    = rd_req && !empty;
  assign count_nx = count + CW'(wr_ok) - CW'(rd_ok);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      count <= count_nx;
      empty <= (count_nx == '0);
      full  <= (count_nx == CNT_FULL);
      if (wr_req && full) overflow <= 1'b1;
    end
  end

  // R7: overflow is sticky
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R7: a write while full does not move the write pointer
  p_drop_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req) |=> $stable(wptr));
  // R6: flags never both set
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  // R5: occupancy bounded by depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);
  // R5: ignored read on empty keeps output
  p_empty_read_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req) |=> $stable(rd_data));
endmodule

// File: rtl/event_timestamp_unit.sv
module event_timestamp_unit
  import ts_pkg::*;
#(
  parameter int unsigned COARSE_W = TS_COARSE_W,
  parameter int unsigned FINE_W   = TS_FINE_W,
  parameter int unsigned DIV      = TS_DIV,
  parameter int unsigned DEPTH    = TS_DEPTH,
  localparam int unsigned WORD_W  = COARSE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              trig_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              overflow
);
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;
  logic                capture;

  ts_time_counter #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .DIV(DIV)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .coarse(coarse), .fine(fine)
  );

  ts_trig_edge u_edge (
    .clk(clk), .rst(rst), .trig_in(trig_in), .capture(capture)
  );

  ts_event_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_req(capture), .wr_data({coarse, fine}),
    .rd_req(rd_en), .rd_data(rd_data),
    .empty(empty), .full(full), .overflow(overflow)
  );

  // R3: a capture into a non-full buffer clears empty on the next cycle
  p_capture_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (capture && !full) |=> !empty);
endmodule

// File: tb/tb_event_timestamp_unit.sv
module tb_event_timestamp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, trig_in = 1'b0, rd_en = 1'b0;
  logic [19:0] rd_data;
  logic        empty, full, overflow;

  int total = 0, bad = 0;
  int ph = 0;
  string tag_rd = "R5";

  logic [15:0] m_coarse = '0;
  int          m_fine = 0;
  bit          m_prev = 0, m_ovf = 0;
  logic [19:0] m_rd = '0;
  logic [19:0] q[$];

  always #10 clk = ~clk;

  event_timestamp_unit dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .trig_in(trig_in), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one fast cycle; entered and left at a falling edge
  task automatic cyc(input bit t, input bit r, input bit tk);
    int cnt0;
    bit rise;
    trig_in = t; rd_en = r; tick_en = tk;
    @(posedge clk);
    cnt0 = q.size();
    rise = t && !m_prev;            // R4 edge rule
    m_prev = t;
    if (r && cnt0 > 0) m_rd = q.pop_front();   // R5
    if (rise) begin
      if (cnt0 < 8) q.push_back({m_coarse, 4'(m_fine)});  // R3 layout
      else m_ovf = 1;                                    // R7 drop
    end
    if (tk) begin m_coarse++; m_fine = 0; end            // R1, R2
    else if (m_fine < 9) m_fine++;
    #1;
    chk(tag_rd, rd_data, m_rd);
    chk("R6 empty", 20'(empty), 20'(q.size() == 0));
    chk("R6 full", 20'(full), 20'(q.size() == 8));
    chk("R7 overflow", 20'(overflow), 20'(m_ovf));
    @(negedge clk);
    ph++;
  endtask

  task automatic ncyc(input bit t, input bit r);
    cyc(t, r, (ph % 10) == 9);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 rd_data", rd_data, 20'h0);
    chk("R8 empty", 20'(empty), 20'h1);
    chk("R8 full", 20'(full), 20'h0);
    chk("R8 overflow", 20'(overflow), 20'h0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4: triggers at varied sub-period phases, some held high
    tag_rd = "R3 R4 R5 rd_data";
    for (int k = 0; k < 6; k++) begin
      repeat (3 + k) ncyc(0, 0);
      repeat (1 + (k % 3) * 2) ncyc(1, 0);
      ncyc(0, 0);
    end
    // empty-buffer reads ignored after drain (R5)
    repeat (10) ncyc(0, 1);
    // R7: fill past depth, including a trigger alongside a read while full
    tag_rd = "R7 R5 rd_data";
    for (int k = 0; k < 10; k++) begin ncyc(1, 0); ncyc(0, 0); end
    ncyc(1, 1);
    ncyc(0, 0);
    for (int k = 0; k < 4; k++) begin ncyc(0, 1); ncyc(1, 0); ncyc(0, 1); end
    repeat (12) ncyc(0, 1);
    // R1: run coarse to the wrap with a tick every cycle
    tag_rd = "R1 wrap rd_data";
    while (m_coarse != 16'hFFFC) cyc(0, 0, 1);
    for (int k = 0; k < 5; k++) begin cyc(1, 0, 1); cyc(0, 0, 1); end
    ph = 0;
    repeat (4) ncyc(0, 0);
    ncyc(1, 0);
    repeat (12) ncyc(0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule